// File: doc/BRIEF.md
# Missing pulse detector

The block watches a periodic pulse train and raises an alarm when an expected pulse does not arrive. The input passes through a two-flop synchronizer, and each rising edge reloads a retriggerable watchdog timer. The watchdog output stays high for as long as edges keep coming no further apart than the programmed timeout. When an edge is missing, the watchdog runs out and its output falls. That fall launches a second timer, which drives an alarm output high for a programmed number of cycles.

The alarm timer cannot be retriggered. A watchdog fall that arrives while the alarm is still high is dropped. The alarm does not get longer and no second alarm follows from that fall.

Both lengths are plain inputs counted in clock cycles. The block has no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain level. For steady operation, set the timeout to no fewer cycles than the input period.

Top module: `miss_pulse_det`

## Requirements
- R1: While reset is asserted, and afterwards until the first synchronized rising edge has armed the watchdog, both `watch_active` and `alarm_out` are 0.
- R2: The input is synchronized with two flip-flops. If `pulse_in` rises before clock edge k, `watch_active` is still 0 after edges k and k+1, and it is 1 after edge k+2.
- R3: Each synchronized rising edge loads the watchdog with `timeout_len`. After the last edge, `watch_active` stays high for exactly `timeout_len` cycles.
- R4: If rising edges arrive every P cycles with P no greater than `timeout_len`, `watch_active` stays high continuously and does not fall during the train.
- R5: When the watchdog runs out, `alarm_out` rises in the same cycle that `watch_active` falls, provided no alarm is already in progress.
- R6: An alarm stays high for exactly `alarm_len` cycles. The value used is the one present on the cycle the watchdog ran out.
- R7: If the watchdog falls while an alarm is high, that fall is ignored. The alarm keeps its original length and no further alarm follows from it.
- R8: If `timeout_len` is 0, input edges never arm the watchdog. If `alarm_len` is 0, a watchdog fall produces no alarm.
- R9: If `timeout_len` is shorter than the input period, the watchdog falls once per period, and each fall produces one alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_in | input | 1 | Asynchronous pulse train that is monitored |
| timeout_len | input | CNT_W | Watchdog timeout, in cycles |
| alarm_len | input | CNT_W | Alarm pulse length, in cycles |
| watch_active | output | 1 | High while the watchdog is armed |
| alarm_out | output | 1 | Alarm pulse |

## Verification
The assertions check several properties on every clock cycle:
- arming after a synchronized edge;
- the alarm launching on a watchdog fall;
- the exact alarm width against the length that was latched;
- no alarm rising without a watchdog fall;
- the alarm ending after its last count;
- silence before the first arming.

Other behaviour can only be shown by the bench's scenarios. These cover the synchronizer latency counted from the pin, continuity under periodic trains of different rates, and the number of watchdog falls and alarms per train. They also cover dropping a fall during a long alarm and a reset that cuts an alarm short.

// File: rtl/miss_pulse_det_pkg.sv
package miss_pulse_det_pkg;
  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/msd_edge_sync.sv
module msd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/msd_timer.sv
module msd_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter bit          RETRIG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             load;

  if (RETRIG) begin : g_retrig
    assign load = start;
  end else begin : g_single
    assign load = start & ~busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      busy  <= (len != '0);
      cnt_q <= len;
    end else if (busy) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) busy <= 1'b0;
    end
  end

  assign last = busy & (cnt_q == ONE) & ~load;
endmodule

// File: rtl/miss_pulse_det.sv
module miss_pulse_det
  import miss_pulse_det_pkg::*;
#(
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic [CNT_W-1:0] timeout_len,
  input  logic [CNT_W-1:0] alarm_len,
  output logic             watch_active,
  output logic             alarm_out
);
  logic rise_evt;
  logic wd_expire;
  logic alarm_last;

  msd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pulse_in),
    .rise     (rise_evt)
  );

  // Watchdog: every synchronized edge reloads it.
  msd_timer #(.CNT_W(CNT_W), .RETRIG(1'b1)) u_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rise_evt),
    .len   (timeout_len),
    .busy  (watch_active),
    .last  (wd_expire)
  );

  // Alarm: launched in the cycle the watchdog runs out, ignores starts while busy.
  msd_timer #(.CNT_W(CNT_W), .RETRIG(1'b0)) u_alarm (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wd_expire),
    .len   (alarm_len),
    .busy  (alarm_out),
    .last  (alarm_last)
  );
endmodule

// File: rtl/miss_pulse_det_chk.sv
module miss_pulse_det_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] timeout_len,
  input logic [CNT_W-1:0] alarm_len,
  input logic             rise_evt,
  input logic             watch_active,
  input logic             alarm_out,
  input logic             alarm_last
);
  logic             armed;
  logic             al_q;
  logic [CNT_W-1:0] alen_q;
  logic [CNT_W-1:0] len_lat;
  logic [CNT_W:0]   run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      al_q    <= 1'b0;
      alen_q  <= '0;
      len_lat <= '0;
      run_len <= '0;
    end else begin
      if (watch_active) armed <= 1'b1;
      al_q   <= alarm_out;
      alen_q <= alarm_len;
      if (alarm_out && !al_q) len_lat <= alen_q;
      run_len <= alarm_out ? run_len + 1'b1 : '0;
    end
  end

  // R1
  silent_until_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !alarm_out);

  // R3
  edge_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && timeout_len != '0) |=> watch_active);

  // R5
  fall_launches_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(watch_active) && !$past(alarm_out) && $past(alarm_len) != '0) |-> alarm_out);

  // R6
  alarm_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_out) |-> (run_len == {1'b0, len_lat}));

  // R7
  alarm_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_out) |-> $fell(watch_active));

  // R7
  alarm_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_last |=> !alarm_out);

  // R8
  zero_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_len == '0 && !watch_active) |=> !watch_active);
endmodule

bind miss_pulse_det miss_pulse_det_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .timeout_len  (timeout_len),
  .alarm_len    (alarm_len),
  .rise_evt     (rise_evt),
  .watch_active (watch_active),
  .alarm_out    (alarm_out),
  .alarm_last   (alarm_last)
);

// File: tb/miss_pulse_det_test.sv
module miss_pulse_det_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pulse_in = 1'b0;
  logic [CNT_W-1:0] timeout_len = '0;
  logic [CNT_W-1:0] alarm_len = '0;
  logic             watch_active;
  logic             alarm_out;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Monitor counters, sampled at the falling edge.
  int falls = 0, rises = 0, al_hi = 0, wd_hi = 0;
  logic prev_wd = 1'b0, prev_al = 1'b0;

  // columns: period, pulses, timeout, alarm length, expected alarms
  localparam int VECS [0:4][0:4] = '{
    '{10, 5, 12, 4, 1},
    '{10, 5, 10, 3, 1},
    '{10, 4,  9, 3, 4},
    '{ 6, 8, 20, 7, 1},
    '{20, 3, 25, 1, 1}
  };

  miss_pulse_det #(.CNT_W(CNT_W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pulse_in     (pulse_in),
    .timeout_len  (timeout_len),
    .alarm_len    (alarm_len),
    .watch_active (watch_active),
    .alarm_out    (alarm_out)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (prev_wd && !watch_active) falls++;
    if (!prev_al && alarm_out) rises++;
    if (alarm_out) al_hi++;
    if (watch_active) wd_hi++;
    prev_wd = watch_active;
    prev_al = alarm_out;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_train(input int period, input int count);
    for (int i = 0; i < count; i++) begin
      pulse_in = 1'b1;
      wait_cyc(2);
      pulse_in = 1'b0;
      wait_cyc(period - 2);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int f0, r0, h0, w0, n;
    @(negedge clk);
    wait_cyc(2);
    // R1: outputs low during reset
    chk("R1 reset watch", int'(watch_active), 0);
    chk("R1 reset alarm", int'(alarm_out), 0);
    rst_n = 1'b1;
    timeout_len = 16'd5;
    alarm_len = 16'd4;
    r0 = rises;
    wait_cyc(100);
    // R1: no alarm before the first edge
    chk("R1 idle no alarm", rises - r0, 0);
    chk("R1 idle watch", int'(watch_active), 0);

    // Vector table
    for (int v = 0; v < 5; v++) begin
      timeout_len = CNT_W'(VECS[v][2]);
      alarm_len = CNT_W'(VECS[v][3]);
      f0 = falls; r0 = rises; h0 = al_hi;
      send_train(VECS[v][0], VECS[v][1]);
      wait_cyc(VECS[v][2] + VECS[v][3] + 20);
      // R4 R5 R9: falls and alarms per train
      chk($sformatf("R4/R9 falls vec%0d", v), falls - f0, VECS[v][4]);
      chk($sformatf("R5 alarms vec%0d", v), rises - r0, VECS[v][4]);
      // R6: total alarm cycles
      chk($sformatf("R6 alarm cycles vec%0d", v), al_hi - h0, VECS[v][4] * VECS[v][3]);
    end

    // R2 and R3: latency and exact timeout
    do_reset();
    timeout_len = 16'd7;
    alarm_len = 16'd5;
    pulse_in = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 not yet active", int'(watch_active), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 active after third edge", int'(watch_active), 1);
    pulse_in = 1'b0;
    n = 0;
    while (watch_active && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R3 timeout width", n, 7);
    chk("R5 alarm with fall", int'(alarm_out), 1);
    wait_cyc(20);

    // R7: fall during alarm is ignored
    timeout_len = 16'd3;
    alarm_len = 16'd20;
    f0 = falls; r0 = rises; h0 = al_hi;
    send_train(8, 2);
    wait_cyc(40);
    chk("R7 two falls", falls - f0, 2);
    chk("R7 one alarm", rises - r0, 1);
    chk("R7 alarm not extended", al_hi - h0, 20);

    // R8: zero timeout never arms
    timeout_len = 16'd0;
    alarm_len = 16'd4;
    w0 = wd_hi; r0 = rises;
    send_train(8, 3);
    wait_cyc(20);
    chk("R8 zero timeout watch", wd_hi - w0, 0);
    chk("R8 zero timeout alarm", rises - r0, 0);

    // R8: zero alarm length
    timeout_len = 16'd5;
    alarm_len = 16'd0;
    f0 = falls; r0 = rises;
    send_train(8, 1);
    wait_cyc(20);
    chk("R8 zero alarm fall", falls - f0, 1);
    chk("R8 zero alarm none", rises - r0, 0);

    // R1: reset cuts an alarm short
    timeout_len = 16'd4;
    alarm_len = 16'd30;
    send_train(6, 1);
    wait_cyc(2);
    chk("R5 alarm running", int'(alarm_out), 1);
    rst_n = 1'b0;
    wait_cyc(2);
    chk("R1 reset clears alarm", int'(alarm_out), 0);
    chk("R1 reset clears watch", int'(watch_active), 0);
    rst_n = 1'b1;
    r0 = rises;
    wait_cyc(40);
    chk("R1 no alarm after reset", rises - r0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule